// File: doc/BRIEF.md
# Microprogram Sequencer with Address Translation Cache

This block starts and steps a microprogram on behalf of an instruction arbiter. A start request carries an address, a flag saying how to read that address, and a flag saying whether the request belongs to the configure phase or the run phase. With the flag low, the low bits of the address point straight into the control store; this is how resident microcode is reached. With the flag high, the address lies in main memory. A small fully associative cache then turns it into a control-store location. On a miss the block asks an external loader to copy the microprogram in. It waits for the loader to report the control-store base it chose, records that mapping, and starts from that base.

Once running, the block keeps the current control-store address in a register. The store is read through that register, and the word returned is captured in a microinstruction register that drives the execution unit for one cycle. The two top bits of each word select the next address: the next location, a branch taken on a status bit from the execution unit, an unconditional branch, or the end of the program. At the end the block pulses a completion flag and goes idle. Each microinstruction takes two cycles: fetch, then issue. The control store read path is combinational from the address output.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy_o`, `done_o`, `load_req_o`, `cs_rd_o` and `mir_valid_o` are low.
- R2: A start with `start_rp_i` = 0, accepted while idle, leads in the next cycle to a fetch (`cs_rd_o` high) at the low CS_AW bits of `start_addr_i`. The upper address bits are ignored and no load is requested.
- R3: A start with `start_rp_i` = 1 whose (phase, address) pair is cached leads in the next cycle to a fetch at the cached control-store address, with `load_req_o` low.
- R4: A start with `start_rp_i` = 1 that misses raises `load_req_o` in the next cycle with `load_addr_o`/`load_se_o` equal to the start address and phase. These stay steady until `load_done_i`.
- R5: The cycle after `load_done_i` fetches from `load_base_i`. The pair is then cached, and a repeat start with it hits.
- R6: The phase bit is part of the lookup key: the same memory address under the other phase misses.
- R7: With every entry valid, a new mapping replaces the entry used least recently, where both hits and installs count as use.
- R8: Installing a mapping whose base equals the base of an existing entry overwrites that entry, so the old memory address then misses.
- R9: A word read during a fetch cycle appears on `mir_o` with `mir_valid_o` high in the following cycle, for exactly one cycle.
- R10: Bits [63:62] of a word select the next address: 00 = current address + 1; 01 = the target field bits [61:52] if `cond_i` is high during the issue cycle, otherwise + 1; 10 = the target field.
- R11: Code 11 ends the program: `done_o` is high during that word's issue cycle only, and `busy_o` is low the cycle after.
- R12: A start presented while busy is ignored. It changes neither the pending load request nor the program being run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a microprogram (taken only when idle) |
| start_rp_i | input | 1 | 0: address is a control-store address; 1: memory address |
| start_se_i | input | 1 | Phase: 0 configure, 1 run |
| start_addr_i | input | MEM_AW | Start address |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | End-of-program word issued |
| load_req_o | output | 1 | Loader request after a miss |
| load_addr_o | output | MEM_AW | Memory address to load |
| load_se_o | output | 1 | Phase of the load |
| load_done_i | input | 1 | Loader finished |
| load_base_i | input | CS_AW | Control-store base chosen by the loader |
| cs_rd_o | output | 1 | Control-store read this cycle |
| cs_addr_o | output | CS_AW | Control-store address register |
| cs_rdata_i | input | UI_W | Control-store word at `cs_addr_o` |
| mir_o | output | UI_W | Microinstruction register |
| mir_valid_o | output | 1 | `mir_o` is issued this cycle |
| cond_i | input | 1 | Status from the execution unit for conditional branches |

## Verification
The bench builds the block with a 4-entry cache, a 16-bit memory address and the default 10-bit control store with 64-bit words. Four entries let a handful of starts fill the cache. A chosen sequence of hits can then fix which entry is oldest, so eviction order and the overwrite-by-base rule can be checked directly. The 16-bit address leaves upper bits above the control-store width that direct-mode starts can set, showing that those bits are ignored.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SEQ_NEXT = 2'b00,
    SEQ_COND = 2'b01,
    SEQ_JUMP = 2'b10,
    SEQ_END  = 2'b11
  } seq_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MISS  = 2'd1,
    ST_FETCH = 2'd2,
    ST_EXEC  = 2'd3
  } state_e;

endpackage

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int CS_AW = 10
) (
  input  logic [1:0]       seq_i,
  input  logic [CS_AW-1:0] tgt_i,
  input  logic [CS_AW-1:0] csar_i,
  input  logic             cond_i,
  output logic [CS_AW-1:0] next_o,
  output logic             end_o
);

  logic [CS_AW-1:0] inc;
  seq_e             seq;

  assign inc = csar_i + 1'b1;
  assign seq = seq_e'(seq_i);

  always_comb begin
    end_o  = 1'b0;
    next_o = inc;
    case (seq)
      SEQ_NEXT: next_o = inc;
      SEQ_COND: next_o = cond_i ? tgt_i : inc;
      SEQ_JUMP: next_o = tgt_i;
      SEQ_END:  end_o  = 1'b1;
      default:  next_o = inc;
    endcase
  end

endmodule

// File: rtl/useq_restab.sv
module useq_restab #(
  parameter  int ENTRIES = 8,
  parameter  int TAG_W   = 33,
  parameter  int CS_AW   = 10,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [CS_AW-1:0] lk_cs_o,
  output logic [IDX_W-1:0] lk_idx_o,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             inst_i,
  input  logic [TAG_W-1:0] inst_tag_i,
  input  logic [CS_AW-1:0] inst_cs_i
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] vld_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [CS_AW-1:0]   cs_q  [ENTRIES];
  logic [IDX_W-1:0]   age_q [ENTRIES];
  logic [IDX_W-1:0]   age_d [ENTRIES];

  logic [ENTRIES-1:0] hit_vec, same_vec, old_vec;
  logic [IDX_W-1:0]   same_idx, free_idx, old_idx, slot, touched;
  logic               do_touch;

  // Per-entry compares
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g]  = vld_q[g] && (tag_q[g] == lk_tag_i);
    assign same_vec[g] = vld_q[g] && (cs_q[g] == inst_cs_i);
    assign old_vec[g]  = (age_q[g] == OLDEST);
  end

  // Priority encoders, lowest index wins
  always_comb begin
    lk_idx_o = '0;
    same_idx = '0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i])  lk_idx_o = IDX_W'(i);
      if (same_vec[i]) same_idx = IDX_W'(i);
      if (!vld_q[i])   free_idx = IDX_W'(i);
      if (old_vec[i])  old_idx  = IDX_W'(i);
    end
  end

  assign lk_hit_o = |hit_vec;
  assign lk_cs_o  = cs_q[lk_idx_o];

  // Victim: entry already mapped to this base, else a free one, else the oldest
  always_comb begin
    if (|same_vec)      slot = same_idx;
    else if (!(&vld_q)) slot = free_idx;
    else                slot = old_idx;
  end

  assign do_touch = inst_i | touch_i;
  assign touched  = inst_i ? slot : touch_idx_i;

  always_comb begin
    vld_d = vld_q;
    if (inst_i) vld_d[slot] = 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);

    always_comb begin
      if (GI == touched)                 age_d[g] = '0;
      else if (age_q[g] < age_q[touched]) age_d[g] = age_q[g] + 1'b1;
      else                                age_d[g] = age_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age_q[g] <= GI;
      else if (do_touch) age_q[g] <= age_d[g];
    end

    always_ff @(posedge clk) begin
      if (inst_i && (slot == GI)) begin
        tag_q[g] <= inst_tag_i;
        cs_q[g]  <= inst_cs_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (inst_i) vld_q <= vld_d;
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int MEM_AW     = 32,
  parameter int CS_AW      = 10,
  parameter int UI_W       = 64,
  parameter int RT_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_rp_i,
  input  logic              start_se_i,
  input  logic [MEM_AW-1:0] start_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              load_req_o,
  output logic [MEM_AW-1:0] load_addr_o,
  output logic              load_se_o,
  input  logic              load_done_i,
  input  logic [CS_AW-1:0]  load_base_i,
  output logic              cs_rd_o,
  output logic [CS_AW-1:0]  cs_addr_o,
  input  logic [UI_W-1:0]   cs_rdata_i,
  output logic [UI_W-1:0]   mir_o,
  output logic              mir_valid_o,
  input  logic              cond_i
);

  localparam int TAG_W = MEM_AW + 1;
  localparam int IDX_W = $clog2(RT_ENTRIES);

  state_e             state_q, state_d;
  logic [CS_AW-1:0]   csar_q, csar_d;
  logic               csar_en;
  logic [UI_W-1:0]    mir_q;
  logic               mir_en;
  logic [TAG_W-1:0]   pend_q;
  logic               pend_en;

  logic               lk_hit;
  logic [CS_AW-1:0]   lk_cs;
  logic [IDX_W-1:0]   lk_idx;
  logic               touch, inst;
  logic [CS_AW-1:0]   nxt_cs;
  logic               is_end;

  useq_restab #(
    .ENTRIES (RT_ENTRIES),
    .TAG_W   (TAG_W),
    .CS_AW   (CS_AW)
  ) u_restab (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_tag_i    ({start_se_i, start_addr_i}),
    .lk_hit_o    (lk_hit),
    .lk_cs_o     (lk_cs),
    .lk_idx_o    (lk_idx),
    .touch_i     (touch),
    .touch_idx_i (lk_idx),
    .inst_i      (inst),
    .inst_tag_i  (pend_q),
    .inst_cs_i   (load_base_i)
  );

  useq_nextaddr #(
    .CS_AW (CS_AW)
  ) u_nextaddr (
    .seq_i  (mir_q[UI_W-1 -: 2]),
    .tgt_i  (mir_q[UI_W-3 -: CS_AW]),
    .csar_i (csar_q),
    .cond_i (cond_i),
    .next_o (nxt_cs),
    .end_o  (is_end)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    csar_d  = csar_q;
    csar_en = 1'b0;
    mir_en  = 1'b0;
    pend_en = 1'b0;
    touch   = 1'b0;
    inst    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!start_rp_i) begin
            csar_d  = start_addr_i[CS_AW-1:0];
            csar_en = 1'b1;
            state_d = ST_FETCH;
          end else if (lk_hit) begin
            csar_d  = lk_cs;
            csar_en = 1'b1;
            touch   = 1'b1;
            state_d = ST_FETCH;
          end else begin
            pend_en = 1'b1;
            state_d = ST_MISS;
          end
        end
      end
      ST_MISS: begin
        if (load_done_i) begin
          inst    = 1'b1;
          csar_d  = load_base_i;
          csar_en = 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mir_en  = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (is_end) begin
          state_d = ST_IDLE;
        end else begin
          csar_d  = nxt_cs;
          csar_en = 1'b1;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       csar_q <= '0;
    else if (csar_en) csar_q <= csar_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mir_q <= '0;
    else if (mir_en) mir_q <= cs_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= {start_se_i, start_addr_i};
  end

  // Outputs
  assign busy_o      = (state_q != ST_IDLE);
  assign load_req_o  = (state_q == ST_MISS);
  assign load_addr_o = pend_q[MEM_AW-1:0];
  assign load_se_o   = pend_q[MEM_AW];
  assign cs_rd_o     = (state_q == ST_FETCH);
  assign cs_addr_o   = csar_q;
  assign mir_o       = mir_q;
  assign mir_valid_o = (state_q == ST_EXEC);
  assign done_o      = (state_q == ST_EXEC) && is_end;

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int MEM_AW = 32,
  parameter int CS_AW  = 10,
  parameter int UI_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              start_rp_i,
  input logic [CS_AW-1:0]  start_lo,
  input logic              busy_o,
  input logic              done_o,
  input logic              load_req_o,
  input logic [MEM_AW-1:0] load_addr_o,
  input logic              load_se_o,
  input logic              load_done_i,
  input logic [CS_AW-1:0]  load_base_i,
  input logic              cs_rd_o,
  input logic [CS_AW-1:0]  cs_addr_o,
  input logic [UI_W-1:0]   cs_rdata_i,
  input logic [UI_W-1:0]   mir_o,
  input logic              mir_valid_o,
  input logic              cond_i
);

  a_r1_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_req_o, cs_rd_o, mir_valid_o}));

  a_r2_direct_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !start_rp_i) |=>
      (cs_rd_o && !load_req_o && (cs_addr_o == $past(start_lo))));

  a_r4_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req_o && !load_done_i) |=>
      (load_req_o && $stable(load_addr_o) && $stable(load_se_o)));

  a_r5_base_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req_o && load_done_i) |=> (cs_rd_o && (cs_addr_o == $past(load_base_i))));

  a_r9_mir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rd_o |=> (mir_valid_o && (mir_o == $past(cs_rdata_i))));

  a_r9_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    mir_valid_o |=> !mir_valid_o);

  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_valid_o && (mir_o[UI_W-1 -: 2] == 2'b00)) |=>
      (cs_rd_o && (cs_addr_o == $past(cs_addr_o) + 1'b1)));

  a_r10_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_valid_o && (mir_o[UI_W-1 -: 2] == 2'b10)) |=>
      (cs_rd_o && (cs_addr_o == $past(mir_o[UI_W-3 -: CS_AW]))));

  a_r10_cond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_valid_o && (mir_o[UI_W-1 -: 2] == 2'b01) && cond_i) |=>
      (cs_rd_o && (cs_addr_o == $past(mir_o[UI_W-3 -: CS_AW]))));

  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r11_done_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> mir_valid_o);

endmodule

bind useq_sequencer useq_sequencer_chk #(
  .MEM_AW (MEM_AW),
  .CS_AW  (CS_AW),
  .UI_W   (UI_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_rp_i  (start_rp_i),
  .start_lo    (start_addr_i[CS_AW-1:0]),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .load_req_o  (load_req_o),
  .load_addr_o (load_addr_o),
  .load_se_o   (load_se_o),
  .load_done_i (load_done_i),
  .load_base_i (load_base_i),
  .cs_rd_o     (cs_rd_o),
  .cs_addr_o   (cs_addr_o),
  .cs_rdata_i  (cs_rdata_i),
  .mir_o       (mir_o),
  .mir_valid_o (mir_valid_o),
  .cond_i      (cond_i)
);

// File: tb/test_useq_sequencer.sv
`timescale 1ns/1ps
module test_useq_sequencer;

  localparam int MEM_AW = 16;
  localparam int CS_AW  = 10;
  localparam int UI_W   = 64;
  localparam int NENT   = 4;
  localparam int DEPTH  = 1 << CS_AW;

  logic              clk;
  logic              rst_n;
  logic              start, start_rp, start_se;
  logic [MEM_AW-1:0] start_addr;
  logic              busy, done, load_req, load_se, load_done;
  logic [MEM_AW-1:0] load_addr;
  logic [CS_AW-1:0]  load_base;
  logic              cs_rd;
  logic [CS_AW-1:0]  cs_addr;
  logic [UI_W-1:0]   cs_rdata, mir;
  logic              mir_valid, cond;

  logic [UI_W-1:0]   cs_mem [DEPTH];
  logic [UI_W-1:0]   exp_q [$];
  logic [UI_W-1:0]   mon_w;
  int                n_chk, n_bad;

  useq_sequencer #(
    .MEM_AW (MEM_AW), .CS_AW (CS_AW), .UI_W (UI_W), .RT_ENTRIES (NENT)
  ) i_useq_sequencer (
    .clk (clk), .rst_n (rst_n),
    .start_i (start), .start_rp_i (start_rp), .start_se_i (start_se),
    .start_addr_i (start_addr), .busy_o (busy), .done_o (done),
    .load_req_o (load_req), .load_addr_o (load_addr), .load_se_o (load_se),
    .load_done_i (load_done), .load_base_i (load_base),
    .cs_rd_o (cs_rd), .cs_addr_o (cs_addr), .cs_rdata_i (cs_rdata),
    .mir_o (mir), .mir_valid_o (mir_valid), .cond_i (cond)
  );

  assign cs_rdata = cs_mem[cs_addr];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [UI_W-1:0] mk(input logic [1:0] s, input logic [CS_AW-1:0] t,
                                         input logic [51:0] p);
    return {s, t, p};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Expected issue order from the sequencing rules of R10/R11
  task automatic push_trace(input logic [CS_AW-1:0] start_cs, input logic c);
    logic [CS_AW-1:0] pc = start_cs;
    for (int k = 0; k < 64; k++) begin
      logic [UI_W-1:0] w = cs_mem[pc];
      exp_q.push_back(w);
      if (w[63:62] == 2'b11) break;
      else if (w[63:62] == 2'b10) pc = w[61:52];
      else if (w[63:62] == 2'b01 && c) pc = w[61:52];
      else pc = pc + 1'b1;
    end
  endtask

  // Monitor: compare each issued microinstruction against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mir_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12", "unexpected microinstruction", mir, 64'h0);
        end else begin
          mon_w = exp_q.pop_front();
          check(mir == mon_w, "R10", "issued word", mir, mon_w);
          check(done == (mon_w[63:62] == 2'b11), "R11", "done pulse", 64'(done),
                64'(mon_w[63:62] == 2'b11));
        end
      end else if (done) begin
        check(1'b0, "R11", "done without issue", 64'(done), 64'h0);
      end
    end
  end

  task automatic launch(input logic rp, input logic se, input logic [MEM_AW-1:0] a,
                        input logic miss, input logic [CS_AW-1:0] cs, input logic c,
                        input logic poke, input string req);
    @(negedge clk);
    start = 1'b1; start_rp = rp; start_se = se; start_addr = a; cond = c;
    push_trace(cs, c);
    @(negedge clk);
    start = 1'b0;
    if (miss) begin
      check(load_req == 1'b1, "R4", {req, " load request"}, 64'(load_req), 64'h1);
      check(load_addr == a, "R4", {req, " load address"}, 64'(load_addr), 64'(a));
      check(load_se == se, "R4", {req, " load phase"}, 64'(load_se), 64'(se));
      if (poke) begin
        start = 1'b1; start_rp = 1'b0; start_addr = 16'h0100;
        @(negedge clk);
        start = 1'b0;
        check(load_req && load_addr == a, "R12", "start while busy", 64'(load_addr), 64'(a));
      end
      repeat (2) @(negedge clk);
      check(load_req == 1'b1 && load_addr == a, "R4", {req, " request held"},
            64'(load_req), 64'h1);
      load_done = 1'b1; load_base = cs;
      @(negedge clk);
      load_done = 1'b0;
    end else begin
      check(load_req == 1'b0, "R3", {req, " no load on hit/direct"}, 64'(load_req), 64'h0);
    end
    check(cs_rd == 1'b1 && cs_addr == cs, req, "first fetch address", 64'(cs_addr), 64'(cs));
    for (int k = 0; k < 300 && busy; k++) @(negedge clk);
    check(busy == 1'b0, "R11", {req, " returns idle"}, 64'(busy), 64'h0);
    check(exp_q.size() == 0, "R9", {req, " all words issued"}, 64'(exp_q.size()), 64'h0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; start_rp = 1'b0; start_se = 1'b0; start_addr = '0;
    load_done = 1'b0; load_base = '0; cond = 1'b0;
    for (int i = 0; i < DEPTH; i++) cs_mem[i] = mk(2'b11, '0, 52'(i) | 52'hABC_0000_0000);
    cs_mem[10'h010] = mk(2'b00, 10'h000, 52'h11);
    cs_mem[10'h011] = mk(2'b01, 10'h020, 52'h22);
    cs_mem[10'h020] = mk(2'b10, 10'h030, 52'h33);
    cs_mem[10'h100] = mk(2'b00, 10'h000, 52'h44);
    cs_mem[10'h101] = mk(2'b00, 10'h000, 52'h55);
    cs_mem[10'h200] = mk(2'b00, 10'h000, 52'h66);

    repeat (2) @(negedge clk);
    check({busy, done, load_req, cs_rd, mir_valid} == 5'b0, "R1", "outputs in reset",
          64'({busy, done, load_req, cs_rd, mir_valid}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, load_req, cs_rd, mir_valid} == 5'b0, "R1", "outputs after reset",
          64'({busy, done, load_req, cs_rd, mir_valid}), 64'h0);

    // Direct mode, upper address bits set (R2), branch taken and not taken (R10)
    launch(1'b0, 1'b1, 16'hFC10, 1'b0, 10'h010, 1'b1, 1'b0, "R2");
    launch(1'b0, 1'b0, 16'h0010, 1'b0, 10'h010, 1'b0, 1'b0, "R10");
    launch(1'b0, 1'b1, 16'h8100, 1'b0, 10'h100, 1'b0, 1'b0, "R9");

    // Translation: miss then hit (R4, R5, R3), with a start poked while busy (R12)
    launch(1'b1, 1'b1, 16'h1000, 1'b1, 10'h200, 1'b0, 1'b1, "R5");
    launch(1'b1, 1'b1, 16'h1000, 1'b0, 10'h200, 1'b0, 1'b0, "R3");
    // Same address, other phase misses (R6)
    launch(1'b1, 1'b0, 16'h1000, 1'b1, 10'h240, 1'b0, 1'b0, "R6");
    launch(1'b1, 1'b1, 16'h2000, 1'b1, 10'h280, 1'b0, 1'b0, "R5");
    launch(1'b1, 1'b1, 16'h3000, 1'b1, 10'h2C0, 1'b0, 1'b0, "R5");
    // Refresh A, then a fifth mapping evicts B (R7)
    launch(1'b1, 1'b1, 16'h1000, 1'b0, 10'h200, 1'b0, 1'b0, "R7");
    launch(1'b1, 1'b1, 16'h4000, 1'b1, 10'h300, 1'b0, 1'b0, "R7");
    launch(1'b1, 1'b1, 16'h1000, 1'b0, 10'h200, 1'b0, 1'b0, "R7");
    launch(1'b1, 1'b0, 16'h1000, 1'b1, 10'h240, 1'b0, 1'b0, "R7");
    launch(1'b1, 1'b1, 16'h3000, 1'b0, 10'h2C0, 1'b0, 1'b0, "R7");
    // Overwrite by base: new mapping at 0x200 drops the old one (R8)
    launch(1'b1, 1'b1, 16'h5000, 1'b1, 10'h200, 1'b0, 1'b0, "R8");
    launch(1'b1, 1'b1, 16'h5000, 1'b0, 10'h200, 1'b0, 1'b0, "R8");
    launch(1'b1, 1'b1, 16'h1000, 1'b1, 10'h380, 1'b0, 1'b0, "R8");

    repeat (3) @(negedge clk);
    check(busy == 1'b0 && mir_valid == 1'b0, "R12", "quiet at end", 64'(busy), 64'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule